// File: doc/BRIEF.md
# Interrupt and Event Request Register

This block is the eight-bit interrupt and event status register of a small processor core. Request strobes arrive grouped by priority class: three classes for interrupts (high, mid, low) and two for events (high, low). Each strobe sets a sticky flag that stays set until software writes it back to zero. The register also holds one individual enable for each of the two lower-priority interrupt levels and a single global enable. The block combines these into an interrupt-pending signal for the core and reports the index of the most urgent armed level.

Interrupt classes map to levels in reverse order. A high-class source raises level 0, a mid-class source raises level 1 and a low-class source raises level 2. Level 0 is the most urgent and has no enable of its own, so only the global enable gates it. The event flags are visible on a separate event-pending output and never interrupt the core. The core writes the whole register through one write port and sees its current value at all times on a read output.

Top module: `intr_req_status`

## Requirements
- R1: A synchronous active-high reset clears all eight register bits on the clock edge where it is sampled.
- R2: A strobe on irqClassReq sets a request bit at the next clock edge: bit 0 (low class) sets register bit 4 (level 2), bit 1 (mid class) sets register bit 3 (level 1), and bit 2 (high class) sets register bit 2 (level 0).
- R3: A strobe on evtClassReq sets an event bit at the next clock edge: bit 0 (low class) sets register bit 1 and bit 1 (high class) sets register bit 0.
- R4: Request and event bits (register bits 4 to 0) keep their value across any number of cycles without a write.
- R5: A write (wrEn high) loads wrData into all eight bits at the clock edge. Bit 7 is the enable for level 2, bit 6 is the enable for level 1 and bit 5 is the global enable. regValue always shows the stored value.
- R6: When a write and a request strobe for the same bit fall in the same cycle, the bit ends up set, whatever wrData holds for it.
- R7: irqPending is high only when global enable bit 5 is set and at least one level is armed. Level 0 is armed by bit 2 alone. Level 1 is armed by bits 3 and 6 together. Level 2 is armed by bits 4 and 7 together.
- R8: irqLevel gives the lowest-numbered armed level (0, 1 or 2). It reads 3 when no level is armed.
- R9: Event bits never affect irqPending or irqLevel. evtPending is high exactly when register bit 0 or bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | CPU write strobe |
| wrData | input | 8 | CPU write data |
| irqClassReq | input | 3 | Interrupt strobes by class: bit 0 low, bit 1 mid, bit 2 high |
| evtClassReq | input | 2 | Event strobes by class: bit 0 low, bit 1 high |
| regValue | output | 8 | Current register contents |
| irqPending | output | 1 | An enabled interrupt request is waiting |
| irqLevel | output | 2 | Most urgent armed level, 3 when none |
| evtPending | output | 1 | An event request is waiting |

## Verification
Every register change, whether from a write, a strobe or a reset, shows on regValue one clock edge after the cycle in which it was driven. irqPending, irqLevel and evtPending are decoded from the stored value without another register, so they are due in the same cycle as regValue. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It then compares all four outputs at the next falling edge, which is exactly one edge after the stimulus.

// File: rtl/intr_req_pkg.sv
package intr_req_pkg;
  localparam int IRQ_LEVELS = 3;
  localparam int EVT_LEVELS = 2;
  localparam int REG_W      = 2 * IRQ_LEVELS + EVT_LEVELS;
  localparam int EVT_LSB    = 0;
  localparam int REQ_LSB    = EVT_LSB + EVT_LEVELS;
  localparam int GIE_BIT    = REQ_LSB + IRQ_LEVELS;
  localparam int EN_LSB     = GIE_BIT + 1;
  localparam int LVL_W      = $clog2(IRQ_LEVELS + 1);
  localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(IRQ_LEVELS);

  typedef struct packed {
    logic             wrLoad;
    logic [REG_W-1:0] wrValue;
    logic [REG_W-1:0] setMask;
  } regStrobes_t;
endpackage

// File: rtl/intr_req_ctrl.sv
module intr_req_ctrl
  import intr_req_pkg::*;
(
  input  logic                  wrEn,
  input  logic [REG_W-1:0]      wrData,
  input  logic [IRQ_LEVELS-1:0] irqClassReq,
  input  logic [EVT_LEVELS-1:0] evtClassReq,
  input  logic [REG_W-1:0]      regValue,
  output regStrobes_t           strobes,
  output logic                  irqPending,
  output logic [LVL_W-1:0]      irqLevel,
  output logic                  evtPending
);
  logic [REG_W-1:0]      setMask;
  logic [IRQ_LEVELS-1:0] levelEnabled;
  logic [IRQ_LEVELS-1:0] levelArmed;

  // Class order is the reverse of level order for both request kinds.
  always_comb begin
    setMask = '0;
    for (int c = 0; c < IRQ_LEVELS; c++)
      setMask[REQ_LSB + (IRQ_LEVELS - 1 - c)] = irqClassReq[c];
    for (int c = 0; c < EVT_LEVELS; c++)
      setMask[EVT_LSB + (EVT_LEVELS - 1 - c)] = evtClassReq[c];
  end

  assign strobes.wrLoad  = wrEn;
  assign strobes.wrValue = wrData;
  assign strobes.setMask = setMask;

  genvar k;
  generate
    for (k = 0; k < IRQ_LEVELS; k++) begin : g_level
      if (k == 0) begin : g_top
        assign levelEnabled[k] = regValue[GIE_BIT];
      end else begin : g_gated
        assign levelEnabled[k] = regValue[GIE_BIT] & regValue[EN_LSB + k - 1];
      end
      assign levelArmed[k] = levelEnabled[k] & regValue[REQ_LSB + k];
    end
  endgenerate

  always_comb begin
    irqLevel = LVL_NONE;
    for (int l = IRQ_LEVELS - 1; l >= 0; l--)
      if (levelArmed[l]) irqLevel = LVL_W'(l);
  end

  assign irqPending = |levelArmed;
  assign evtPending = |regValue[EVT_LSB +: EVT_LEVELS];
endmodule

// File: rtl/intr_req_datapath.sv
module intr_req_datapath
  import intr_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  regStrobes_t      strobes,
  output logic [REG_W-1:0] regValue
);
  logic [REG_W-1:0] regQ;
  logic [REG_W-1:0] regNext;

  // A strobe is ORed in after the write so that no request is lost.
  always_comb begin
    regNext = strobes.wrLoad ? strobes.wrValue : regQ;
    regNext = regNext | strobes.setMask;
  end

  always_ff @(posedge clk) begin
    if (rst) regQ <= '0;
    else     regQ <= regNext;
  end

  assign regValue = regQ;
endmodule

// File: rtl/intr_req_status.sv
module intr_req_status
  import intr_req_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [REG_W-1:0]      wrData,
  input  logic [IRQ_LEVELS-1:0] irqClassReq,
  input  logic [EVT_LEVELS-1:0] evtClassReq,
  output logic [REG_W-1:0]      regValue,
  output logic                  irqPending,
  output logic [LVL_W-1:0]      irqLevel,
  output logic                  evtPending
);
  regStrobes_t      strobes;
  logic [REG_W-1:0] regQ;

  intr_req_ctrl u_ctrl (
    .wrEn       (wrEn),
    .wrData     (wrData),
    .irqClassReq(irqClassReq),
    .evtClassReq(evtClassReq),
    .regValue   (regQ),
    .strobes    (strobes),
    .irqPending (irqPending),
    .irqLevel   (irqLevel),
    .evtPending (evtPending)
  );

  intr_req_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .regValue(regQ)
  );

  assign regValue = regQ;
endmodule

// File: rtl/intr_req_checks.sv
module intr_req_checks
  import intr_req_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  wrEn,
  input logic [IRQ_LEVELS-1:0] irqClassReq,
  input logic [EVT_LEVELS-1:0] evtClassReq,
  input logic [REG_W-1:0]      regValue,
  input logic                  irqPending,
  input logic [LVL_W-1:0]      irqLevel
);
  localparam logic [REG_W-1:0] REQ_MASK = REG_W'((1 << (IRQ_LEVELS + EVT_LEVELS)) - 1);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> regValue == '0);

  p_low_class_sets_r2: assert property (@(posedge clk) disable iff (rst)
    irqClassReq[0] |=> regValue[REQ_LSB + IRQ_LEVELS - 1]);

  p_high_class_sets_r2: assert property (@(posedge clk) disable iff (rst)
    irqClassReq[IRQ_LEVELS-1] |=> regValue[REQ_LSB]);

  p_evt_low_sets_r3: assert property (@(posedge clk) disable iff (rst)
    evtClassReq[0] |=> regValue[EVT_LSB + EVT_LEVELS - 1]);

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> ((($past(regValue) & REQ_MASK) & ~regValue) == '0));

  p_pending_needs_gie_r7: assert property (@(posedge clk) disable iff (rst)
    irqPending |-> regValue[GIE_BIT]);

  p_level_has_request_r8: assert property (@(posedge clk) disable iff (rst)
    irqPending |-> (irqLevel < LVL_W'(IRQ_LEVELS)) && regValue[REQ_LSB + int'(irqLevel)]);

  p_idle_level_r8: assert property (@(posedge clk) disable iff (rst)
    !irqPending |-> irqLevel == LVL_NONE);

  p_events_no_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irqPending |-> regValue[REQ_LSB +: IRQ_LEVELS] != '0);
endmodule

bind intr_req_status intr_req_checks u_checks (
  .clk        (clk),
  .rst        (rst),
  .wrEn       (wrEn),
  .irqClassReq(irqClassReq),
  .evtClassReq(evtClassReq),
  .regValue   (regValue),
  .irqPending (irqPending),
  .irqLevel   (irqLevel)
);

// File: tb/test_intr_req_status.sv
module test_intr_req_status;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       wrEn;
  logic [7:0] wrData;
  logic [2:0] irqClassReq;
  logic [1:0] evtClassReq;
  logic [7:0] regValue;
  logic       irqPending;
  logic [1:0] irqLevel;
  logic       evtPending;

  int tests = 0;
  int fails = 0;
  int model = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_req_status i_intr_req_status (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .irqClassReq(irqClassReq), .evtClassReq(evtClassReq),
    .regValue(regValue), .irqPending(irqPending),
    .irqLevel(irqLevel), .evtPending(evtPending)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int expLevel(int m);
    bit gie = m[5];
    if (gie && m[2]) return 0;
    if (gie && m[6] && m[3]) return 1;
    if (gie && m[7] && m[4]) return 2;
    return 3;
  endfunction

  task automatic compareAll(string tag);
    int lvl = expLevel(model);
    check({tag, " regValue"}, int'(regValue), model);
    check({tag, " irqPending (R7)"}, int'(irqPending), (lvl != 3) ? 1 : 0);
    check({tag, " irqLevel (R8)"}, int'(irqLevel), lvl);
    check({tag, " evtPending (R9)"}, int'(evtPending), (model[1] | model[0]) ? 1 : 0);
  endtask

  // Drive one cycle from the falling edge, advance the model at the rising
  // edge, and compare at the following falling edge.
  task automatic step(string tag, bit r, bit we, logic [7:0] d, logic [2:0] irq, logic [1:0] evt);
    rst = r; wrEn = we; wrData = d; irqClassReq = irq; evtClassReq = evt;
    @(posedge clk);
    if (r) model = 0;
    else begin
      if (we) model = int'(d);
      for (int c = 0; c < 3; c++) if (irq[c]) model[2 + (2 - c)] = 1'b1;
      for (int c = 0; c < 2; c++) if (evt[c]) model[1 - c] = 1'b1;
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    rst = 1'b1; wrEn = 1'b0; wrData = '0; irqClassReq = '0; evtClassReq = '0;
    @(negedge clk);
    step("R1 reset", 1, 0, 8'h00, 3'b000, 2'b00);
    // R2 class to level mapping, inverted
    step("R2 low class", 0, 0, 8'h00, 3'b001, 2'b00);
    step("R2 mid class", 0, 0, 8'h00, 3'b010, 2'b00);
    step("R2 high class", 0, 0, 8'h00, 3'b100, 2'b00);
    // R4 sticky across idle cycles
    for (int i = 0; i < 4; i++) step("R4 hold", 0, 0, 8'h00, 3'b000, 2'b00);
    // R5 write clears
    step("R5 write zero", 0, 1, 8'h00, 3'b000, 2'b00);
    // R3 event mapping
    step("R3 evt low", 0, 0, 8'h00, 3'b000, 2'b01);
    step("R3 evt high", 0, 0, 8'h00, 3'b000, 2'b10);
    // R9 events with every enable set never interrupt
    step("R9 enables with events", 0, 1, 8'hE3, 3'b000, 2'b00);
    step("R9 hold", 0, 0, 8'h00, 3'b000, 2'b00);
    // R6 set beats a clearing write
    step("R6 set wins", 0, 1, 8'h00, 3'b010, 2'b01);
    // R7 level 1 without its enable: not pending
    step("R7 no IE1", 0, 1, 8'h28, 3'b000, 2'b00);
    step("R7 IE1 set", 0, 1, 8'h68, 3'b000, 2'b00);
    step("R7 GIE off", 0, 1, 8'hC8, 3'b000, 2'b00);
    step("R7 level0 GIE only", 0, 1, 8'h24, 3'b000, 2'b00);
    // R8 priority order
    step("R8 all armed", 0, 1, 8'hFC, 3'b000, 2'b00);
    step("R8 level0 cleared", 0, 1, 8'hF8, 3'b000, 2'b00);
    step("R8 level1 cleared", 0, 1, 8'hF0, 3'b000, 2'b00);
    step("R8 none", 0, 1, 8'hE0, 3'b000, 2'b00);
    // R1 reset from a full register
    step("R1 fill", 0, 1, 8'hFF, 3'b000, 2'b00);
    step("R1 reset again", 1, 0, 8'h00, 3'b111, 2'b11);
    // R5 random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit r = ($urandom_range(0, 99) == 0);
      bit we = ($urandom_range(0, 3) == 0);
      step("R5 random", r, we, 8'($urandom), 3'($urandom_range(0, 7) & $urandom_range(0, 7)),
           2'($urandom_range(0, 3) & $urandom_range(0, 3)));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule